// File: doc/BRIEF.md
# Pipelined-to-Peripheral Bus Bridge

This block joins a pipelined, high-speed system bus to a simple, low-power peripheral bus that shares its clock. On the fast side it behaves as a slave: it samples an address phase, then holds the following data phase open with wait states. On the slow side it is the only master. It turns each single fast-side read or write into one three-step peripheral access: idle, setup, then enable.

The top four address bits choose one of four peripheral slots. An address outside those slots gets a two-cycle error response and causes no peripheral access. When an access ends, the peripheral address, direction and write data keep their values until the next access enters setup. This saves switching power on the slow bus. A fast-side master may place its next address phase in the enable cycle of the current access. The bridge then goes straight into the next access without passing through idle.

Top module: `periph_bridge`

## Requirements
- R1: After synchronous reset the bridge is idle: `hs_ready_out`=1, `hs_resp`=0 (OKAY), `pb_sel`=0, `pb_enable`=0, `pb_addr`=0, `pb_write`=0.
- R2: A transfer is accepted at a clock edge where `hs_sel`=1, `hs_ready_in`=1 and `hs_trans` is 2 (first beat) or 3 (follow-on beat). Codes 0 (idle) and 1 (busy), or `hs_sel`=0, start no peripheral access and leave `hs_ready_out` high.
- R3: In the cycle after acceptance (the data phase), `hs_ready_out` is 0 and `hs_resp` is 0. `hs_wdata` is sampled at the end of that cycle.
- R4: In the next cycle (setup), exactly one `pb_sel` bit is high and `pb_enable` is 0. `pb_addr` and `pb_write` carry the accepted address and direction. For a write, `pb_wdata` carries the sampled write data.
- R5: In the cycle after setup (enable), `pb_enable` is 1 and `pb_sel`, `pb_addr` and `pb_write` are unchanged. `hs_ready_out` is 1 in this cycle only, which ends the data phase.
- R6: During the enable cycle of a read, `hs_rdata` equals the read data of the selected slot. `pb_rdata` bits [32*k+31:32*k] belong to slot k.
- R7: Address bits [15:12] with a value k in 0..3 select slot k, driving `pb_sel[k]`. Values 4..15 are unmapped.
- R8: An unmapped address produces `hs_resp`=1 with `hs_ready_out`=0 in the data-phase cycle, then `hs_resp`=1 with `hs_ready_out`=1 in the next cycle. `pb_sel` stays 0 throughout.
- R9: Between accesses, `pb_sel` and `pb_enable` are 0. `pb_addr`, `pb_write` and `pb_wdata` hold their last values until the next setup cycle.
- R10: A transfer accepted during an enable cycle is followed by its own data-phase wait cycle and then its setup cycle, with no idle cycle between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both buses |
| rst | input | 1 | Synchronous active-high reset |
| hs_sel | input | 1 | Fast-side slave select for this bridge |
| hs_trans | input | 2 | Transfer type: 0 idle, 1 busy, 2 first beat, 3 follow-on |
| hs_write | input | 1 | 1 = write, 0 = read (address phase) |
| hs_addr | input | ADDR_W (16) | Fast-side address (address phase) |
| hs_wdata | input | DATA_W (32) | Write data (data phase) |
| hs_ready_in | input | 1 | Fast-bus ready, showing that the previous data phase is ending |
| hs_ready_out | output | 1 | Bridge ready; low inserts wait states |
| hs_resp | output | 1 | Response: 0 OKAY, 1 ERROR |
| hs_rdata | output | DATA_W (32) | Read data returned to the fast side |
| pb_sel | output | NUM_SLOTS (4) | One-hot peripheral slot select |
| pb_enable | output | 1 | Enable-phase strobe |
| pb_write | output | 1 | Peripheral access direction |
| pb_addr | output | ADDR_W (16) | Peripheral address |
| pb_wdata | output | DATA_W (32) | Peripheral write data |
| pb_rdata | input | NUM_SLOTS*DATA_W (128) | Read data of all slots, slot k at bits [32*k+31:32*k] |

## Verification
The properties assume that `hs_ready_in` mirrors `hs_ready_out`. In other words, the bridge is the only slave whose data phase is open, so no address phase is offered while the bridge stalls. The properties also assume that `hs_trans`, `hs_addr` and `hs_write` are valid whenever `hs_sel` is high. The bench ties `hs_ready_in` to `hs_ready_out` and changes inputs only on falling edges. It raises a new address phase only in cycles where the bridge reports ready, including the enable cycle used for the back-to-back case.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CAPT   = 3'd1,
        ST_SETUP  = 3'd2,
        ST_ENABLE = 3'd3,
        ST_ERRA   = 3'd4,
        ST_ERRB   = 3'd5
    } br_state_t;

    localparam logic [1:0] TR_IDLE   = 2'd0;
    localparam logic [1:0] TR_BUSY   = 2'd1;
    localparam logic [1:0] TR_NONSEQ = 2'd2;
    localparam logic [1:0] TR_SEQ    = 2'd3;

    function automatic logic trans_active(input logic [1:0] t);
        return (t == TR_NONSEQ) || (t == TR_SEQ);
    endfunction

    function automatic logic state_ready(input br_state_t s);
        return (s == ST_IDLE) || (s == ST_ENABLE) || (s == ST_ERRB);
    endfunction

endpackage

// File: rtl/bridge_slot_decode.sv
module bridge_slot_decode #(
    parameter int ADDR_W    = 16,
    parameter int SLOT_LSB  = 12,
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot,
    output logic              mapped
);
    localparam int FIELD_W = ADDR_W - SLOT_LSB;

    logic [FIELD_W-1:0] field;

    assign field  = addr[ADDR_W-1:SLOT_LSB];
    assign mapped = field < FIELD_W'(NUM_SLOTS);
    assign slot   = field[SLOT_W-1:0];
endmodule

// File: rtl/bridge_seq.sv
module bridge_seq
    import bridge_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  logic      mapped,
    output br_state_t state_q
);
    br_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_ENABLE, ST_ERRB: begin
                if (accept) state_d = mapped ? ST_CAPT : ST_ERRA;
                else        state_d = ST_IDLE;
            end
            ST_CAPT:  state_d = ST_SETUP;
            ST_SETUP: state_d = ST_ENABLE;
            ST_ERRA:  state_d = ST_ERRB;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/bridge_rdmux.sv
module bridge_rdmux #(
    parameter int DATA_W    = 32,
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic [NUM_SLOTS*DATA_W-1:0] bus,
    input  logic [SLOT_W-1:0]           idx,
    input  logic                        en,
    output logic [DATA_W-1:0]           out
);
    logic [DATA_W-1:0] slice [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slice
        assign slice[g] = bus[g*DATA_W +: DATA_W];
    end

    assign out = en ? slice[idx] : '0;
endmodule

// File: rtl/periph_bridge.sv
module periph_bridge
    import bridge_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_LSB  = 12
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        hs_sel,
    input  logic [1:0]                  hs_trans,
    input  logic                        hs_write,
    input  logic [ADDR_W-1:0]           hs_addr,
    input  logic [DATA_W-1:0]           hs_wdata,
    input  logic                        hs_ready_in,
    output logic                        hs_ready_out,
    output logic                        hs_resp,
    output logic [DATA_W-1:0]           hs_rdata,
    output logic [NUM_SLOTS-1:0]        pb_sel,
    output logic                        pb_enable,
    output logic                        pb_write,
    output logic [ADDR_W-1:0]           pb_addr,
    output logic [DATA_W-1:0]           pb_wdata,
    input  logic [NUM_SLOTS*DATA_W-1:0] pb_rdata
);
    localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    br_state_t         state_q;
    logic              accept;
    logic              dec_mapped;
    logic [SLOT_W-1:0] dec_slot;

    logic [ADDR_W-1:0] lat_addr;
    logic              lat_write;
    logic [SLOT_W-1:0] lat_slot;
    logic [SLOT_W-1:0] pb_slot_q;
    logic              pb_active;

    assign accept = hs_sel && trans_active(hs_trans) && hs_ready_in
                    && state_ready(state_q);

    bridge_slot_decode #(
        .ADDR_W(ADDR_W), .SLOT_LSB(SLOT_LSB),
        .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
    ) u_dec (
        .addr(hs_addr), .slot(dec_slot), .mapped(dec_mapped)
    );

    bridge_seq u_seq (
        .clk(clk), .rst(rst), .accept(accept),
        .mapped(dec_mapped), .state_q(state_q)
    );

    // Address-phase capture
    always_ff @(posedge clk) begin
        if (rst) begin
            lat_addr  <= '0;
            lat_write <= 1'b0;
            lat_slot  <= '0;
        end else if (accept) begin
            lat_addr  <= hs_addr;
            lat_write <= hs_write;
            lat_slot  <= dec_slot;
        end
    end

    // Peripheral-side registers: loaded only on entry to setup, frozen otherwise
    always_ff @(posedge clk) begin
        if (rst) begin
            pb_addr   <= '0;
            pb_write  <= 1'b0;
            pb_slot_q <= '0;
            pb_wdata  <= '0;
        end else if (state_q == ST_CAPT) begin
            pb_addr   <= lat_addr;
            pb_write  <= lat_write;
            pb_slot_q <= lat_slot;
            if (lat_write) pb_wdata <= hs_wdata;
        end
    end

    assign pb_active = (state_q == ST_SETUP) || (state_q == ST_ENABLE);
    assign pb_enable = (state_q == ST_ENABLE);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
        assign pb_sel[g] = pb_active && (pb_slot_q == SLOT_W'(g));
    end

    bridge_rdmux #(
        .DATA_W(DATA_W), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
    ) u_rdmux (
        .bus(pb_rdata), .idx(pb_slot_q),
        .en(pb_enable && !pb_write), .out(hs_rdata)
    );

    assign hs_ready_out = state_ready(state_q);
    assign hs_resp      = (state_q == ST_ERRA) || (state_q == ST_ERRB);
endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
    parameter int ADDR_W    = 16,
    parameter int NUM_SLOTS = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 hs_sel,
    input logic [1:0]           hs_trans,
    input logic                 hs_ready_in,
    input logic                 hs_ready_out,
    input logic                 hs_resp,
    input logic [NUM_SLOTS-1:0] pb_sel,
    input logic                 pb_enable,
    input logic                 pb_write,
    input logic [ADDR_W-1:0]    pb_addr
);
    logic acc;
    assign acc = hs_sel && hs_trans[1] && hs_ready_in && hs_ready_out;

    assert_wait_after_accept_R3: assert property (@(posedge clk) disable iff (rst)
        acc |=> !hs_ready_out);

    assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pb_sel));

    assert_setup_to_enable_R5: assert property (@(posedge clk) disable iff (rst)
        (pb_sel != '0 && !pb_enable) |=>
            (pb_enable && $stable(pb_sel) && $stable(pb_addr) && $stable(pb_write)));

    assert_enable_has_sel_R5: assert property (@(posedge clk) disable iff (rst)
        pb_enable |-> (pb_sel != '0 && hs_ready_out));

    assert_error_two_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        (hs_resp && !hs_ready_out) |=> (hs_resp && hs_ready_out));

    assert_error_no_select_R8: assert property (@(posedge clk) disable iff (rst)
        hs_resp |-> (pb_sel == '0));

    assert_hold_between_R9: assert property (@(posedge clk) disable iff (rst)
        (pb_sel == '0) |=> (pb_sel != '0 || ($stable(pb_addr) && $stable(pb_write))));
endmodule

bind periph_bridge bridge_checker #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS)
) u_bridge_checker (
    .clk(clk), .rst(rst), .hs_sel(hs_sel), .hs_trans(hs_trans),
    .hs_ready_in(hs_ready_in), .hs_ready_out(hs_ready_out), .hs_resp(hs_resp),
    .pb_sel(pb_sel), .pb_enable(pb_enable), .pb_write(pb_write), .pb_addr(pb_addr)
);

// File: tb/periph_bridge_bench.sv
`timescale 1ns/1ps
module periph_bridge_bench;
    logic         clk = 1'b0;
    logic         rst;
    logic         hs_sel;
    logic [1:0]   hs_trans;
    logic         hs_write;
    logic [15:0]  hs_addr;
    logic [31:0]  hs_wdata;
    logic         hs_ready_out;
    logic         hs_resp;
    logic [31:0]  hs_rdata;
    logic [3:0]   pb_sel;
    logic         pb_enable;
    logic         pb_write;
    logic [15:0]  pb_addr;
    logic [31:0]  pb_wdata;
    logic [127:0] pb_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    for (genvar k = 0; k < 4; k++) begin : g_periph
        assign pb_rdata[k*32 +: 32] = {8'hA0 + 8'(k), 8'h5C, pb_addr};
    end

    periph_bridge u_periph_bridge (
        .clk(clk), .rst(rst), .hs_sel(hs_sel), .hs_trans(hs_trans),
        .hs_write(hs_write), .hs_addr(hs_addr), .hs_wdata(hs_wdata),
        .hs_ready_in(hs_ready_out), .hs_ready_out(hs_ready_out),
        .hs_resp(hs_resp), .hs_rdata(hs_rdata), .pb_sel(pb_sel),
        .pb_enable(pb_enable), .pb_write(pb_write), .pb_addr(pb_addr),
        .pb_wdata(pb_wdata), .pb_rdata(pb_rdata)
    );

    function automatic logic [31:0] exp_rd(input int slot, input logic [15:0] a);
        return {8'hA0 + 8'(slot), 8'h5C, a};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_idle();
        hs_sel = 1'b0; hs_trans = 2'd0; hs_write = 1'b0; hs_addr = 16'hFFFF;
    endtask

    task automatic drive_addr(input logic wr, input logic [15:0] a, input logic [1:0] t);
        hs_sel = 1'b1; hs_trans = t; hs_write = wr; hs_addr = a;
    endtask

    // From the setup cycle onward; caller is at the setup-cycle negedge.
    task automatic tail_access(input logic wr, input logic [15:0] a, input logic [31:0] wd);
        int slot = int'(a[15:12]);
        check(pb_sel == 4'(1 << slot), "R7 slot select", 64'(pb_sel), 64'(1 << slot));
        check(!pb_enable && !hs_ready_out, "R4 setup phase", {pb_enable, hs_ready_out}, 0);
        check(pb_addr == a && pb_write == wr, "R4 setup addr/dir",
              {pb_write, pb_addr}, {wr, a});
        if (wr) check(pb_wdata == wd, "R4 write data", 64'(pb_wdata), 64'(wd));
        @(negedge clk);
        check(pb_enable && hs_ready_out && pb_sel == 4'(1 << slot) && pb_addr == a,
              "R5 enable phase", {pb_enable, hs_ready_out, pb_sel, pb_addr},
              {1'b1, 1'b1, 4'(1 << slot), a});
        if (!wr) check(hs_rdata == exp_rd(slot, a), "R6 read data",
                       64'(hs_rdata), 64'(exp_rd(slot, a)));
    endtask

    task automatic run_xfer(input logic wr, input logic [15:0] a, input logic [31:0] wd);
        drive_addr(wr, a, 2'd2);
        @(negedge clk);
        check(!hs_ready_out && !hs_resp && pb_sel == 0, "R3 wait in data phase",
              {hs_ready_out, hs_resp, pb_sel}, 0);
        drive_idle();
        hs_wdata = wd;
        @(negedge clk);
        hs_wdata = ~wd;
        tail_access(wr, a, wd);
        @(negedge clk);
        check(pb_sel == 0 && !pb_enable && hs_ready_out, "R9 bus released",
              {pb_sel, pb_enable, hs_ready_out}, 1);
        check(pb_addr == a && pb_write == wr, "R9 addr/dir held",
              {pb_write, pb_addr}, {wr, a});
        if (wr) check(pb_wdata == wd, "R9 wdata held", 64'(pb_wdata), 64'(wd));
    endtask

    task automatic run_error(input logic [15:0] a);
        logic [15:0] prev = pb_addr;
        drive_addr(1'b0, a, 2'd3);
        @(negedge clk);
        drive_idle();
        check(hs_resp && !hs_ready_out && pb_sel == 0, "R8 error first cycle",
              {hs_resp, hs_ready_out, pb_sel}, {1'b1, 1'b0, 4'd0});
        @(negedge clk);
        check(hs_resp && hs_ready_out && pb_sel == 0, "R8 error second cycle",
              {hs_resp, hs_ready_out, pb_sel}, {1'b1, 1'b1, 4'd0});
        @(negedge clk);
        check(!hs_resp && hs_ready_out && pb_sel == 0 && pb_addr == prev,
              "R8 error done, no access", {hs_resp, pb_sel, pb_addr}, {1'b0, 4'd0, prev});
    endtask

    task automatic run_ignored();
        logic [15:0] prev = pb_addr;
        drive_addr(1'b1, 16'h1234, 2'd0);
        @(negedge clk);
        hs_trans = 2'd1;
        @(negedge clk);
        hs_sel = 1'b0; hs_trans = 2'd2;
        @(negedge clk);
        drive_idle();
        @(negedge clk);
        check(pb_sel == 0 && hs_ready_out && !hs_resp && pb_addr == prev,
              "R2 idle/busy/unselected ignored", {pb_sel, hs_ready_out, pb_addr},
              {4'd0, 1'b1, prev});
    endtask

    task automatic run_back_to_back();
        drive_addr(1'b0, 16'h1040, 2'd2);
        @(negedge clk);
        drive_idle();
        @(negedge clk);
        tail_access(1'b0, 16'h1040, 32'h0);
        drive_addr(1'b1, 16'h2088, 2'd2);   // address phase in the enable cycle
        @(negedge clk);
        check(!hs_ready_out && pb_sel == 0 && pb_addr == 16'h1040, "R10 second data phase",
              {hs_ready_out, pb_sel, pb_addr}, {1'b0, 4'd0, 16'h1040});
        drive_idle();
        hs_wdata = 32'hFEED_0002;
        @(negedge clk);
        hs_wdata = 32'h0;
        check(pb_sel == 4'b0100, "R10 direct setup after capture", 64'(pb_sel), 4);
        tail_access(1'b1, 16'h2088, 32'hFEED_0002);
        @(negedge clk);
        check(pb_sel == 0 && pb_addr == 16'h2088, "R9 held after pipelined pair",
              {pb_sel, pb_addr}, {4'd0, 16'h2088});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive_idle();
        hs_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(hs_ready_out && !hs_resp && pb_sel == 0 && !pb_enable && pb_addr == 0 && !pb_write,
              "R1 reset state", {hs_ready_out, hs_resp, pb_sel, pb_enable, pb_addr, pb_write},
              {1'b1, 1'b0, 4'd0, 1'b0, 16'd0, 1'b0});
        run_xfer(1'b1, 16'h0010, 32'hDEAD_BEEF);
        run_xfer(1'b0, 16'h1004, 32'h0);
        run_xfer(1'b1, 16'h2ABC, 32'h1357_9BDF);
        run_xfer(1'b0, 16'h3FFC, 32'h0);
        run_ignored();
        run_error(16'h4000);
        run_error(16'hF00C);
        run_back_to_back();
        run_xfer(1'b0, 16'h0000, 32'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule